// File: doc/BRIEF.md
# Ordered Virtual-Network Send Filter

This block sits beside the switch allocator of a router input port. For every virtual channel (VC) of the port it reports whether that VC may ask for its output port now without letting a younger flit overtake an older one. The check applies only in a virtual network that is configured as ordered. The allocator ANDs the permit vector with its own credit and free-VC eligibility before its stage-one arbitration.

Each VC presents three things: a flag saying it is ready for allocation, the output port it wants, and the timestamp taken when its head flit arrived. Timestamps come from a free-running counter and may wrap. Age is therefore judged on the modular difference of two stamps. One stamp counts as older than another when that difference is small and positive. The filter is purely combinational. The clock and reset ports feed only the embedded assertions.

Top module: `ord_send_filter`

## Requirements
- R1: A VC whose virtual network has its ordered bit at 0 always gets permit = 1, whatever the other inputs are.
- R2: In an ordered virtual network, VC i gets permit = 0 when some VC j of the same virtual network is ready, requests the same output port, and is strictly older than VC i.
- R3: A VC whose ready flag is 0 never blocks another VC.
- R4: A ready, older VC that requests a different output port does not block.
- R5: Two VCs with equal timestamps never block each other.
- R6: VCs of a different virtual network never block, even when both networks are ordered.
- R7: The virtual network of VC i is i / VC_PER_VN (integer division). Bit k of `vn_ordered` governs VCs k*VC_PER_VN through k*VC_PER_VN + VC_PER_VN - 1.
- R8: Stamp A is older than stamp B when d = (B - A) mod 2^TS_W satisfies 1 <= d <= 2^(TS_W-1) - 1. When d equals 2^(TS_W-1), neither stamp is older than the other.
- R9: `permit` follows its inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only to sample the assertions |
| rst_n | input | 1 | Active-low reset; disables the assertions |
| vc_ready | input | NUM_VC | Per-VC ready-for-allocation flag |
| vc_port | input | NUM_VC*PORT_W | Requested output port; VC i is in bits [i*PORT_W +: PORT_W] |
| vc_stamp | input | NUM_VC*TS_W | Head-flit arrival stamp; VC i is in bits [i*TS_W +: TS_W] |
| vn_ordered | input | NUM_VC/VC_PER_VN | Ordered bit for each virtual network |
| permit | output | NUM_VC | Per-VC send permit |

## Verification
Two functions can act on the same output bit in one input vector: the ordering block raised by an older same-port peer, and the bypass for an unordered network. Sometimes the blocking peer sits in another network whose own ordered bit differs. The bench provokes both cases by sweeping `vn_ordered` over all of its values while random vectors crowd many ready VCs onto two ports, with stamps packed close together and across the wrap point. Each bit of the result is judged against a model in the bench. That model applies the requirement order directly: first network membership, then the ordered bit, then ready, port and modular age.

// File: rtl/ord_pkg.sv
package ord_pkg;
    // default geometry of one router input port
    parameter int unsigned OSF_NUM_VC    = 8;
    parameter int unsigned OSF_VC_PER_VN = 4;
    parameter int unsigned OSF_PORT_W    = 3;
    parameter int unsigned OSF_TS_W      = 8;
endpackage

// File: rtl/ord_age_cmp.sv
// Wrap-safe age comparison of two arrival stamps.
module ord_age_cmp #(
    parameter int unsigned TS_W = ord_pkg::OSF_TS_W
) (
    input  logic [TS_W-1:0] cand_stamp,
    input  logic [TS_W-1:0] peer_stamp,
    output logic            peer_older
);
    logic [TS_W-1:0] gap;

    always_comb begin
        gap        = cand_stamp - peer_stamp;
        // peer is older when the modular gap is nonzero and in the lower half
        peer_older = (gap != '0) && !gap[TS_W-1];
    end
endmodule

// File: rtl/ord_vc_check.sv
// Ordering check for one candidate VC against the VCs of its own network.
module ord_vc_check #(
    parameter int unsigned VC_PER_VN = ord_pkg::OSF_VC_PER_VN,
    parameter int unsigned PORT_W    = ord_pkg::OSF_PORT_W,
    parameter int unsigned TS_W      = ord_pkg::OSF_TS_W
) (
    input  logic                        ordered,
    input  logic [PORT_W-1:0]           cand_port,
    input  logic [TS_W-1:0]             cand_stamp,
    input  logic [VC_PER_VN-1:0]        peer_ready,
    input  logic [VC_PER_VN*PORT_W-1:0] peer_port,
    input  logic [VC_PER_VN*TS_W-1:0]   peer_stamp,
    output logic                        permit
);
    logic [VC_PER_VN-1:0] older;
    logic [VC_PER_VN-1:0] conflict;

    for (genvar p = 0; p < VC_PER_VN; p++) begin : g_peer
        ord_age_cmp #(.TS_W(TS_W)) u_age (
            .cand_stamp (cand_stamp),
            .peer_stamp (peer_stamp[p*TS_W +: TS_W]),
            .peer_older (older[p])
        );
        // the candidate compared with itself has a zero gap, so it never conflicts
        assign conflict[p] = peer_ready[p] && older[p]
                          && (peer_port[p*PORT_W +: PORT_W] == cand_port);
    end

    always_comb begin
        permit = !ordered || (conflict == '0);
    end
endmodule

// File: rtl/ord_send_filter.sv
// Per-port send filter that enforces point-to-point order in ordered virtual networks.
module ord_send_filter #(
    parameter int unsigned NUM_VC    = ord_pkg::OSF_NUM_VC,
    parameter int unsigned VC_PER_VN = ord_pkg::OSF_VC_PER_VN,
    parameter int unsigned PORT_W    = ord_pkg::OSF_PORT_W,
    parameter int unsigned TS_W      = ord_pkg::OSF_TS_W,
    localparam int unsigned NUM_VN   = NUM_VC / VC_PER_VN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_VC-1:0]        vc_ready,
    input  logic [NUM_VC*PORT_W-1:0] vc_port,
    input  logic [NUM_VC*TS_W-1:0]   vc_stamp,
    input  logic [NUM_VN-1:0]        vn_ordered,
    output logic [NUM_VC-1:0]        permit
);
    // true when another ready VC of the same network wants the same port
    function automatic logic has_rival(int unsigned idx);
        logic hit;
        int unsigned base;
        hit  = 1'b0;
        base = (idx / VC_PER_VN) * VC_PER_VN;
        for (int unsigned k = 0; k < VC_PER_VN; k++) begin
            if ((base + k) != idx && vc_ready[base + k]
                && vc_port[(base + k)*PORT_W +: PORT_W] == vc_port[idx*PORT_W +: PORT_W])
                hit = 1'b1;
        end
        return hit;
    endfunction

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        localparam int unsigned VN   = g / VC_PER_VN;
        localparam int unsigned BASE = VN * VC_PER_VN;
        localparam logic [NUM_VC-1:0] OTHERS =
            ((NUM_VC'(1) << VC_PER_VN) - NUM_VC'(1)) << BASE & ~(NUM_VC'(1) << g);

        ord_vc_check #(
            .VC_PER_VN (VC_PER_VN),
            .PORT_W    (PORT_W),
            .TS_W      (TS_W)
        ) u_check (
            .ordered    (vn_ordered[VN]),
            .cand_port  (vc_port[g*PORT_W +: PORT_W]),
            .cand_stamp (vc_stamp[g*TS_W +: TS_W]),
            .peer_ready (vc_ready[BASE +: VC_PER_VN]),
            .peer_port  (vc_port[BASE*PORT_W +: VC_PER_VN*PORT_W]),
            .peer_stamp (vc_stamp[BASE*TS_W +: VC_PER_VN*TS_W]),
            .permit     (permit[g])
        );

        // R1
        unordered_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !vn_ordered[VN] |-> permit[g]);
        // R2
        block_needs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !permit[g] |-> vn_ordered[VN]);
        // R3
        block_needs_ready_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !permit[g] |-> ($countones(vc_ready & OTHERS) != 0));
        // R4
        block_needs_same_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !permit[g] |-> has_rival(g));
    end
endmodule

// File: tb/tb_ord_send_filter.sv
module tb_ord_send_filter;
    localparam int NV = 8, VPN = 4, PW = 3, TW = 8, NN = NV / VPN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NV-1:0]    vc_ready;
    logic [NV*PW-1:0] vc_port;
    logic [NV*TW-1:0] vc_stamp;
    logic [NN-1:0]    vn_ordered;
    logic [NV-1:0]    permit;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ord_send_filter #(.NUM_VC(NV), .VC_PER_VN(VPN), .PORT_W(PW), .TS_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .vc_ready(vc_ready), .vc_port(vc_port),
        .vc_stamp(vc_stamp), .vn_ordered(vn_ordered), .permit(permit));

    function automatic logic [NV-1:0] model();
        logic [NV-1:0] r;
        for (int i = 0; i < NV; i++) begin
            int vn = i / VPN;
            r[i] = 1'b1;
            if (vn_ordered[vn]) begin
                for (int j = vn * VPN; j < vn * VPN + VPN; j++) begin
                    int d = (int'(vc_stamp[i*TW +: TW]) - int'(vc_stamp[j*TW +: TW]) + 256) % 256;
                    if (vc_ready[j] && vc_port[j*PW +: PW] == vc_port[i*PW +: PW]
                        && d >= 1 && d <= 127)
                        r[i] = 1'b0;
                end
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [NV-1:0] exp);
        checks++;
        if (permit !== exp) begin
            errors++;
            $display("FAIL %s permit actual %b expected %b", req, permit, exp);
        end
    endtask

    task automatic clear();
        vc_ready = '0; vc_port = '0; vc_stamp = '0; vn_ordered = '0;
    endtask

    task automatic put(int v, int port, int stamp);
        vc_ready[v] = 1'b1;
        vc_port[v*PW +: PW] = PW'(port);
        vc_stamp[v*TW +: TW] = TW'(stamp);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL R9 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear();
        repeat (3) @(negedge clk);
        #1 check("R3 reset idle", 8'hFF);
        rst_n = 1'b1;

        // R1: unordered network never blocks
        settle(); clear(); put(0, 2, 5); put(1, 2, 9); put(2, 2, 20);
        #1 check("R1", 8'hFF);
        // R2: older same-port peer blocks
        settle(); clear(); vn_ordered = 2'b01; put(0, 2, 5); put(1, 2, 9);
        #1 check("R2", 8'hFD);
        // R9: a change between edges shows up at once
        vc_stamp[0*TW +: TW] = 8'd12;
        #1 check("R9", 8'hFE);
        // R3: not-ready older peer does not block
        settle(); clear(); vn_ordered = 2'b01; put(0, 2, 5); put(1, 2, 9); vc_ready[0] = 1'b0;
        #1 check("R3", 8'hFF);
        // R4: different port does not block
        settle(); clear(); vn_ordered = 2'b01; put(0, 3, 5); put(1, 2, 9);
        #1 check("R4", 8'hFF);
        // R5: equal stamps
        settle(); clear(); vn_ordered = 2'b01; put(0, 2, 7); put(1, 2, 7);
        #1 check("R5", 8'hFF);
        // R6: other network's older VC does not block
        settle(); clear(); vn_ordered = 2'b11; put(1, 2, 9); put(4, 2, 1);
        #1 check("R6", 8'hFF);
        // R7: ordered bit 1 covers VCs 4..7 only
        settle(); clear(); vn_ordered = 2'b10; put(0, 1, 1); put(1, 1, 6); put(4, 1, 1); put(5, 1, 6);
        #1 check("R7", 8'hDF);
        // R8: wrap, 250 is older than 3
        settle(); clear(); vn_ordered = 2'b01; put(0, 2, 250); put(1, 2, 3);
        #1 check("R8 wrap", 8'hFD);
        // R8: half-range distance, neither older
        settle(); clear(); vn_ordered = 2'b01; put(0, 2, 0); put(1, 2, 128);
        #1 check("R8 half", 8'hFF);
        // R8: distance 127 is still older
        settle(); clear(); vn_ordered = 2'b01; put(0, 2, 0); put(1, 2, 127);
        #1 check("R8 edge", 8'hFD);

        // R2: sweep of ordered bits with dense random traffic
        for (int n = 0; n < 4000; n++) begin
            int base;
            settle();
            vn_ordered = NN'(n % 4);
            vc_ready = NV'($urandom);
            base = (n % 3 == 0) ? 120 : ((n % 3 == 1) ? 250 : 0);
            for (int v = 0; v < NV; v++) begin
                vc_port[v*PW +: PW] = PW'($urandom % 2);
                vc_stamp[v*TW +: TW] = TW'(base + ($urandom % 12));
            end
            #1 check("R2 sweep", model());
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule